// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Wrong-Path Squash

This block decides conditional branches one stage after fetch, in decode. Fetch always continues sequentially, so a not-taken branch costs nothing. While the branch sits in decode, a dedicated adder forms the branch destination from the incremented PC and the sign-extended word offset. An equality tester compares the two register operands by XOR-ing them and OR-reducing the difference, split into lanes.

When the branch is taken, the block steers the PC mux to the computed destination. It also raises a squash strobe. That strobe turns the instruction fetched behind the branch into a bubble by loading zeros into the decode-side control register, which this block owns, instead of that instruction's control word.

Both equal and not-equal branch forms are supported. Forwarding into decode and any prediction history are outside this block.

Top module: `br_resolve_id`

## Requirements
- R1: `branchTarget` always equals `pcPlus4 + (offset << 2)` modulo 2^PC_W, whatever the flags are. A negative offset moves the target backwards, and the sum wraps at the top of the address space.
- R2: With `isBeq` high and `rsVal` equal to `rtVal`, `pcSel` and `flush` are both 1 in the same cycle.
- R3: With `isBne` high and `rsVal` different from `rtVal`, `pcSel` and `flush` are both 1 in the same cycle.
- R4: With both `isBeq` and `isBne` low, `pcSel` and `flush` are 0 whatever the operands are.
- R5: A branch whose condition fails (`isBeq` with unequal operands, or `isBne` with equal operands, the other flag low) gives `pcSel` = 0 and `flush` = 0. Fetch continues and no cycle is lost.
- R6: With both flags high, the branch is taken regardless of the operands.
- R7: At each clock edge, `decodeCtl` loads `fetchCtl` when `flush` is 0 and loads all zeros when `flush` is 1. Exactly one younger instruction is squashed per taken branch.
- R8: While `rstN` is low, `decodeCtl` is all zeros.
- R9: Every operand bit takes part in the equality test. Operands that differ only in the most significant bit, or only in the least significant bit, are unequal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcPlus4 | input | PC_W | Address of the instruction after the branch |
| offset | input | PC_W | Sign-extended word offset of the branch |
| rsVal | input | DATA_W | First register operand |
| rtVal | input | DATA_W | Second register operand |
| isBeq | input | 1 | Decoded instruction is branch-if-equal |
| isBne | input | 1 | Decoded instruction is branch-if-not-equal |
| fetchCtl | input | CTRL_W | Control word of the instruction just fetched |
| pcSel | output | 1 | 1 selects `branchTarget` as the next PC, 0 selects sequential fetch |
| branchTarget | output | PC_W | Computed branch destination |
| flush | output | 1 | Squash strobe for the younger pipeline register |
| decodeCtl | output | CTRL_W | Control word registered into decode, zeroed on squash |

## Verification
The hardest case to reach is a difference confined to one bit at the edge of an equality lane. A broken lane reduction only shows up when operands differ in exactly one edge bit. The stimulus therefore drives operand pairs that differ only in the MSB and only in the LSB, under both branch forms.

The second hard case is back-to-back taken branches. They prove that squashing zeros exactly one captured control word per taken branch. The vector that follows the pair carries a non-zero fetch word, which shows that capture resumes on the next edge.

// File: rtl/br_pkg.sv
package br_pkg;

  // Strobes sent from branch control to the datapath
  typedef struct packed {
    logic redirect;  // choose branch destination as next PC
    logic squash;    // zero the younger instruction's control word
  } brStrobes_t;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_BOTH = 2'b11
  } brKind_e;

endpackage

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   pcPlus4,
  input  logic [PC_W-1:0]   offset,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [CTRL_W-1:0] fetchCtl,
  input  brStrobes_t        strobes,
  output logic [PC_W-1:0]   branchTarget,
  output logic              operandsEqual,
  output logic [CTRL_W-1:0] decodeCtl
);

  localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  // Destination adder living in decode
  logic [PC_W-1:0] wordOffset;
  assign wordOffset   = offset << 2;
  assign branchTarget = pcPlus4 + wordOffset;

  // Equality: XOR, then per-lane OR reduction, then final OR
  logic [PAD_W-1:0] diffPad;
  logic [LANES-1:0] laneAny;
  assign diffPad = PAD_W'(rsVal ^ rtVal);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneAny[g] = |diffPad[g*LANE_W +: LANE_W];
  end

  assign operandsEqual = ~|laneAny;

  // Decode-side control register with squash-to-zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              decodeCtl <= '0;
    else if (strobes.squash) decodeCtl <= '0;
    else                    decodeCtl <= fetchCtl;
  end

  // R7
  squash_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.squash |=> decodeCtl == '0);

  // R7
  capture_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.squash |=> decodeCtl == $past(fetchCtl));

endmodule

// File: rtl/br_control.sv
module br_control
  import br_pkg::*;
(
  input  logic       isBeq,
  input  logic       isBne,
  input  logic       operandsEqual,
  output brStrobes_t strobes
);

  brKind_e kind;
  logic    taken;

  assign kind = brKind_e'({isBne, isBeq});

  always_comb begin
    unique case (kind)
      BR_NONE: taken = 1'b0;
      BR_EQ:   taken = operandsEqual;
      BR_NE:   taken = ~operandsEqual;
      BR_BOTH: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    strobes.redirect = taken;
    strobes.squash   = taken;
  end

endmodule

// File: rtl/br_resolve_id.sv
module br_resolve_id
  import br_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   pcPlus4,
  input  logic [PC_W-1:0]   offset,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic              isBeq,
  input  logic              isBne,
  input  logic [CTRL_W-1:0] fetchCtl,
  output logic              pcSel,
  output logic [PC_W-1:0]   branchTarget,
  output logic              flush,
  output logic [CTRL_W-1:0] decodeCtl
);

  brStrobes_t strobes;
  logic       operandsEqual;

  br_datapath #(
    .PC_W(PC_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LANE_W(LANE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pcPlus4(pcPlus4), .offset(offset),
    .rsVal(rsVal), .rtVal(rtVal), .fetchCtl(fetchCtl), .strobes(strobes),
    .branchTarget(branchTarget), .operandsEqual(operandsEqual),
    .decodeCtl(decodeCtl)
  );

  br_control u_ctl (
    .isBeq(isBeq), .isBne(isBne), .operandsEqual(operandsEqual),
    .strobes(strobes)
  );

  assign pcSel = strobes.redirect;
  assign flush = strobes.squash;

  // R2
  beq_equal_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isBeq && rsVal == rtVal) |-> (pcSel && flush));

  // R3
  bne_differ_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isBne && rsVal != rtVal) |-> (pcSel && flush));

  // R4
  no_flag_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isBeq && !isBne) |-> (!pcSel && !flush));

  // R5
  failed_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((isBeq && !isBne && rsVal != rtVal) || (isBne && !isBeq && rsVal == rtVal))
      |-> (!pcSel && !flush));

  // R6
  both_flags_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isBeq && isBne) |-> pcSel);

endmodule

// File: tb/tb_br_resolve_id.sv
module tb_br_resolve_id;

  localparam int PC_W   = 32;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PC_W-1:0]   pcPlus4 = '0;
  logic [PC_W-1:0]   offset = '0;
  logic [DATA_W-1:0] rsVal = '0;
  logic [DATA_W-1:0] rtVal = '0;
  logic              isBeq = 1'b0;
  logic              isBne = 1'b0;
  logic [CTRL_W-1:0] fetchCtl = '0;
  logic              pcSel;
  logic [PC_W-1:0]   branchTarget;
  logic              flush;
  logic [CTRL_W-1:0] decodeCtl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  br_resolve_id dut (
    .clk(clk), .rstN(rstN), .pcPlus4(pcPlus4), .offset(offset),
    .rsVal(rsVal), .rtVal(rtVal), .isBeq(isBeq), .isBne(isBne),
    .fetchCtl(fetchCtl), .pcSel(pcSel), .branchTarget(branchTarget),
    .flush(flush), .decodeCtl(decodeCtl)
  );

  typedef struct {
    string             req;
    logic              expSel;
    logic              expFlush;
    logic [PC_W-1:0]   expTarget;
    logic [CTRL_W-1:0] expCtl;
  } item_t;

  item_t sbq[$];

  // Driver: applies one vector on the falling edge and predicts the outputs
  task automatic drive(string req, logic [PC_W-1:0] pc, logic [PC_W-1:0] off,
                       logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                       logic beq, logic bne, logic [CTRL_W-1:0] fc);
    item_t it;
    logic taken;
    @(negedge clk);
    pcPlus4 = pc; offset = off; rsVal = a; rtVal = b;
    isBeq = beq; isBne = bne; fetchCtl = fc;
    taken = (beq && a == b) || (bne && a != b);
    it.req       = req;
    it.expSel    = taken;
    it.expFlush  = taken;
    it.expTarget = pc + off * 4;
    it.expCtl    = taken ? '0 : fc;
    sbq.push_back(it);
  endtask

  // Monitor: samples after the rising edge, before the inputs move again
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (pcSel !== it.expSel || flush !== it.expFlush ||
            branchTarget !== it.expTarget || decodeCtl !== it.expCtl) begin
          fails++;
          $display("FAIL %s: sel=%0b flush=%0b target=%h ctl=%h expected sel=%0b flush=%0b target=%h ctl=%h",
                   it.req, pcSel, flush, branchTarget, decodeCtl,
                   it.expSel, it.expFlush, it.expTarget, it.expCtl);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset holds the decode control word at zero
    fetchCtl = 8'hA5;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (decodeCtl !== '0) begin
      fails++;
      $display("FAIL R8: ctl=%h expected 00", decodeCtl);
    end
    @(negedge clk);
    rstN = 1'b1;

    drive("R4", 32'h0000_1000, 32'h0000_0010, 32'h5, 32'h5, 0, 0, 8'hA5);
    drive("R2", 32'h0000_2000, 32'h0000_0003, 32'h77, 32'h77, 1, 0, 8'h3C);
    drive("R5", 32'h0000_2004, 32'h0000_0003, 32'h77, 32'h78, 1, 0, 8'h3C);
    drive("R3", 32'h0000_3000, 32'h0000_0020, 32'h1, 32'h2, 0, 1, 8'h81);
    drive("R5", 32'h0000_3004, 32'h0000_0020, 32'h9, 32'h9, 0, 1, 8'h81);
    drive("R9", 32'h0000_4000, 32'h1, 32'h8000_0000, 32'h0, 1, 0, 8'h11);
    drive("R9", 32'h0000_4000, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 0, 1, 8'h22);
    drive("R1", 32'h0000_1000, 32'hFFFF_FFFC, 32'h0, 32'h1, 0, 0, 8'h44);  // expect 0xFF0
    drive("R1", 32'hFFFF_FFFC, 32'h0000_0002, 32'h0, 32'h1, 0, 0, 8'h45);  // expect 0x4
    drive("R6", 32'h0000_5000, 32'h4, 32'h6, 32'h6, 1, 1, 8'h5A);
    drive("R6", 32'h0000_5000, 32'h4, 32'h6, 32'h7, 1, 1, 8'h5B);
    drive("R4", 32'h0000_6000, 32'h8, 32'hDEAD, 32'hBEEF, 0, 0, 8'h66);
    // R7: back-to-back taken branches, then capture resumes
    drive("R7", 32'h0000_7000, 32'h2, 32'h3, 32'h3, 1, 0, 8'hF0);
    drive("R7", 32'h0000_7004, 32'h2, 32'h3, 32'h4, 0, 1, 8'hF1);
    drive("R7", 32'h0000_7008, 32'h2, 32'h3, 32'h4, 1, 0, 8'hF2);

    @(negedge clk);
    isBeq = 0; isBne = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule